// File: doc/BRIEF.md
# Serial-Programmed Stereo Attenuator and Output Router

This block sits in a stereo audio path between the sample source and the noise shaper. It takes a pair of 16-bit two's-complement samples (left and right) with a valid strobe. Each input channel is scaled by its own 8-bit gain code. Each of the two outputs then picks its own source from left, right, the halved sum of both, or silence. The block also holds a de-emphasis enable flag for a downstream filter; the filter itself is not part of the block.

Settings come from a microcontroller over three pins: a data line, a shift clock and a latch. All three are sampled by the system clock. A 16-bit word is shifted in most significant bit first. It is committed to the settings when the latch pin rises. The word carries a 2-bit register address in bits [15:14] and a value in bits [7:0].

Each sample is processed against one coherent snapshot of the settings, taken in the cycle the sample is accepted. A sample is never computed with a setting that is partly updated. A low-active clear returns every setting to its default.

Top module: `chanAttnRouter`

## Requirements
- R1: While `rstN` is low, and after it is released, `outValid`, `outOne`, `outTwo` and `deemphOn` are 0. The defaults are gain code 255 on both channels, `outOne` sourced from left, `outTwo` sourced from right, and de-emphasis off.
- R2: A control word is 16 bits, shifted MSB first on rising edges of `serClk`, and committed on the rising edge of `serLatch`. Bits [15:14] select the register: 00 is the left gain code, 01 is the right gain code, 10 is mode. Bits [7:0] are the value.
- R3: A gain code n from 1 to 255 gives floor(x*(n+1)/256). Code 255 therefore passes the sample unchanged.
- R4: Gain code 0 gives exactly 0 on that channel.
- R5: The left gain code scales only the left sample, and the right gain code scales only the right sample.
- R6: In the mode word, bits [1:0] pick the `outOne` source and bits [3:2] pick the `outTwo` source. The source codes are 00 left, 01 right, 10 sum and 11 mute (output 0).
- R7: The sum source outputs floor((L'+R')/2), computed on 17 bits from the attenuated samples and saturated to 16 bits.
- R8: Mode bit 4 sets `deemphOn`. The flag changes only together with a processed sample.
- R9: `outValid` pulses one cycle after `inValid`. The result uses the settings committed before that accepting cycle. Outputs hold their value between pulses.
- R10: A word with address 11 changes no setting.
- R11: Shifting bits without a latch edge changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Low-active clear of all settings and outputs |
| serData | input | 1 | Serial control data |
| serClk | input | 1 | Serial shift clock, bit taken on its rising edge |
| serLatch | input | 1 | Commits the shifted word on its rising edge |
| inValid | input | 1 | Sample pair strobe |
| inLeft | input | 16 | Left input sample, two's complement |
| inRight | input | 16 | Right input sample, two's complement |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| outOne | output | 16 | First processed output |
| outTwo | output | 16 | Second processed output |
| deemphOn | output | 1 | De-emphasis enable for the downstream filter |

## Verification
A wrong gain code or source select is invisible until the next sample. It then shows on the very next `outValid` pulse as a scaled, swapped or zeroed value. For this reason every settings write is followed by at least one sample whose expected value differs under the old and the new setting. A stray commit, such as from an ignored address or a shift without a latch, would corrupt the following sample's outputs. That sample is compared against unchanged settings. A lost or extra strobe shows as a scoreboard underrun or as leftover expected items.

// File: rtl/attnPkg.sv
package attnPkg;
  localparam int DATA_W = 16;
  localparam int ATT_W  = 8;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    SRC_LEFT  = 2'b00,
    SRC_RIGHT = 2'b01,
    SRC_SUM   = 2'b10,
    SRC_MUTE  = 2'b11
  } srcSel_t;

  typedef enum logic [1:0] {
    ADDR_ATT_L = 2'b00,
    ADDR_ATT_R = 2'b01,
    ADDR_MODE  = 2'b10,
    ADDR_NONE  = 2'b11
  } regAddr_t;

  typedef struct packed {
    logic [ATT_W-1:0] attL;
    logic [ATT_W-1:0] attR;
    srcSel_t          srcOne;
    srcSel_t          srcTwo;
    logic             deemph;
  } ctrlBus_t;
endpackage

// File: rtl/ctrlPort.sv
module ctrlPort
  import attnPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     serData,
  input  logic     serClk,
  input  logic     serLatch,
  output ctrlBus_t cfg
);
  localparam int SYNC_TOP = SYNC_STAGES;

  logic [SYNC_TOP:0]   datQ, clkQ, latQ;
  logic                clkRise, latchRise, datBit;
  logic [WORD_W-1:0]   shiftReg;
  regAddr_t            wordAddr;
  logic [ATT_W-1:0]    wordVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      datQ <= '0;
      clkQ <= '0;
      latQ <= '0;
    end else begin
      datQ <= {datQ[SYNC_TOP-1:0], serData};
      clkQ <= {clkQ[SYNC_TOP-1:0], serClk};
      latQ <= {latQ[SYNC_TOP-1:0], serLatch};
    end
  end

  assign datBit    = datQ[SYNC_TOP-1];
  assign clkRise   = clkQ[SYNC_TOP-1] & ~clkQ[SYNC_TOP];
  assign latchRise = latQ[SYNC_TOP-1] & ~latQ[SYNC_TOP];
  assign wordAddr  = regAddr_t'(shiftReg[WORD_W-1 -: 2]);
  assign wordVal   = shiftReg[ATT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (clkRise) shiftReg <= {shiftReg[WORD_W-2:0], datBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg.attL   <= '1;
      cfg.attR   <= '1;
      cfg.srcOne <= SRC_LEFT;
      cfg.srcTwo <= SRC_RIGHT;
      cfg.deemph <= 1'b0;
    end else if (latchRise) begin
      unique case (wordAddr)
        ADDR_ATT_L: cfg.attL <= wordVal;
        ADDR_ATT_R: cfg.attR <= wordVal;
        ADDR_MODE: begin
          cfg.srcOne <= srcSel_t'(wordVal[1:0]);
          cfg.srcTwo <= srcSel_t'(wordVal[3:2]);
          cfg.deemph <= wordVal[4];
        end
        default: ;
      endcase
    end
  end

  // R2
  att_l_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchRise && wordAddr == ADDR_ATT_L |=> cfg.attL == $past(shiftReg[ATT_W-1:0]));
  // R10
  addr_none_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchRise && wordAddr == ADDR_NONE |=> $stable(cfg));
  // R11
  no_latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !latchRise |=> $stable(cfg));
endmodule

// File: rtl/gainPath.sv
module gainPath
  import attnPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlBus_t                 cfg,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inLeft,
  input  logic signed [DATA_W-1:0] inRight,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outOne,
  output logic signed [DATA_W-1:0] outTwo,
  output logic                     deemphOn
);
  localparam int PROD_W = DATA_W + ATT_W + 2;
  localparam int SUM_W  = DATA_W + 1;
  localparam int NCH    = 2;
  localparam logic signed [DATA_W-1:0] MAX_S = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MIN_S = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic signed [DATA_W-1:0] satWide(input logic signed [PROD_W-ATT_W-1:0] v);
    if (v > PROD_W'(signed'(MAX_S)))      return MAX_S;
    else if (v < PROD_W'(signed'(MIN_S))) return MIN_S;
    else                                  return v[DATA_W-1:0];
  endfunction

  function automatic logic signed [DATA_W-1:0] satSum(input logic signed [SUM_W-1:0] v);
    if (v > SUM_W'(signed'(MAX_S)))      return MAX_S;
    else if (v < SUM_W'(signed'(MIN_S))) return MIN_S;
    else                                 return v[DATA_W-1:0];
  endfunction

  logic signed [DATA_W-1:0] chIn   [NCH];
  logic        [ATT_W-1:0]  chCode [NCH];
  logic signed [DATA_W-1:0] chOut  [NCH];

  assign chIn[0]   = inLeft;
  assign chIn[1]   = inRight;
  assign chCode[0] = cfg.attL;
  assign chCode[1] = cfg.attR;

  for (genvar ch = 0; ch < NCH; ch++) begin : gAttn
    logic        [ATT_W:0]           gainVal;
    logic signed [PROD_W-1:0]        prod;
    logic signed [PROD_W-ATT_W-1:0]  scaled;
    always_comb begin
      gainVal = {1'b0, chCode[ch]} + (ATT_W+1)'(1);
      prod    = $signed({{(PROD_W-DATA_W){chIn[ch][DATA_W-1]}}, chIn[ch]})
              * $signed({{(PROD_W-ATT_W-1){1'b0}}, gainVal});
      scaled  = prod[PROD_W-1:ATT_W];
      chOut[ch] = (chCode[ch] == '0) ? '0 : satWide(scaled);
    end
  end

  logic signed [SUM_W-1:0]  sumWide;
  logic signed [SUM_W-1:0]  sumHalf;
  logic signed [DATA_W-1:0] sumOut;

  always_comb begin
    sumWide = SUM_W'(chOut[0]) + SUM_W'(chOut[1]);
    sumHalf = sumWide >>> 1;
    sumOut  = satSum(sumHalf);
  end

  function automatic logic signed [DATA_W-1:0] pick(input srcSel_t s,
      input logic signed [DATA_W-1:0] l, input logic signed [DATA_W-1:0] r,
      input logic signed [DATA_W-1:0] m);
    unique case (s)
      SRC_LEFT:  return l;
      SRC_RIGHT: return r;
      SRC_SUM:   return m;
      default:   return '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outOne   <= '0;
      outTwo   <= '0;
      deemphOn <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outOne   <= pick(cfg.srcOne, chOut[0], chOut[1], sumOut);
        outTwo   <= pick(cfg.srcTwo, chOut[0], chOut[1], sumOut);
        deemphOn <= cfg.deemph;
      end
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outOne) && $stable(outTwo) && $stable(deemphOn) && !outValid);
  // R6
  mute_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && cfg.srcOne == SRC_MUTE |=> outOne == '0);
  // R3
  unity_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && cfg.srcOne == SRC_LEFT && cfg.attL == '1 |=> outOne == $past(inLeft));
endmodule

// File: rtl/chanAttnRouter.sv
module chanAttnRouter
  import attnPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serData,
  input  logic                     serClk,
  input  logic                     serLatch,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inLeft,
  input  logic signed [DATA_W-1:0] inRight,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outOne,
  output logic signed [DATA_W-1:0] outTwo,
  output logic                     deemphOn
);
  ctrlBus_t cfgBus;

  ctrlPort #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .serData(serData), .serClk(serClk),
    .serLatch(serLatch), .cfg(cfgBus)
  );

  gainPath u_path (
    .clk(clk), .rstN(rstN), .cfg(cfgBus), .inValid(inValid),
    .inLeft(inLeft), .inRight(inRight), .outValid(outValid),
    .outOne(outOne), .outTwo(outTwo), .deemphOn(deemphOn)
  );
endmodule

// File: tb/chanAttnRouter_tb.sv
module chanAttnRouter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serData = 1'b0, serClk = 1'b0, serLatch = 1'b0;
  logic inValid = 1'b0;
  logic signed [15:0] inLeft = '0, inRight = '0;
  logic outValid, deemphOn;
  logic signed [15:0] outOne, outTwo;

  always #10 clk = ~clk;

  chanAttnRouter u_dut (.*);

  typedef struct {
    int    e1;
    int    e2;
    bit    eDe;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int mAttL, mAttR, mSrc1, mSrc2;
  bit mDe;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int attn(input int x, input int n);
    if (n == 0) return 0;
    return (x * (n + 1)) >>> 8;
  endfunction

  function automatic int route(input int s, input int l, input int r);
    int m;
    m = (l + r) >>> 1;
    if (m > 32767) m = 32767;
    if (m < -32768) m = -32768;
    case (s)
      0: return l;
      1: return r;
      2: return m;
      default: return 0;
    endcase
  endfunction

  task automatic modelReset();
    mAttL = 255; mAttR = 255; mSrc1 = 0; mSrc2 = 1; mDe = 1'b0;
  endtask

  task automatic shiftWord(input logic [15:0] w, input bit doLatch);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk); serData = w[i];
      repeat (3) @(negedge clk); serClk = 1'b1;
      repeat (3) @(negedge clk); serClk = 1'b0;
    end
    if (doLatch) begin
      repeat (3) @(negedge clk); serLatch = 1'b1;
      repeat (3) @(negedge clk); serLatch = 1'b0;
    end
    repeat (6) @(negedge clk);
    if (doLatch) begin
      case (w[15:14])
        2'b00: mAttL = w[7:0];
        2'b01: mAttR = w[7:0];
        2'b10: begin mSrc1 = w[1:0]; mSrc2 = w[3:2]; mDe = w[4]; end
        default: ;
      endcase
    end
  endtask

  task automatic setMode(input int s1, input int s2, input bit de);
    shiftWord({2'b10, 6'd0, 3'd0, de, 2'(s2), 2'(s1)}, 1'b1);
  endtask

  task automatic sendSample(input int l, input int r, input string tag);
    exp_t e;
    int al, ar;
    al = attn(l, mAttL);
    ar = attn(r, mAttR);
    e.e1 = route(mSrc1, al, ar);
    e.e2 = route(mSrc2, al, ar);
    e.eDe = mDe;
    e.tag = tag;
    @(negedge clk);
    inLeft = 16'(l); inRight = 16'(r); inValid = 1'b1;
    q.push_back(e);
    @(negedge clk);
    inValid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R9", "unexpected outValid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(int'(outOne) == e.e1, e.tag, "outOne", int'(outOne), e.e1);
        chk(int'(outTwo) == e.e2, e.tag, "outTwo", int'(outTwo), e.e2);
        chk(deemphOn == e.eDe, e.tag, "deemphOn", int'(deemphOn), int'(e.eDe));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", "timeout", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (4) @(negedge clk);
    // R1: outputs during and after clear
    chk(outValid == 1'b0 && outOne == 0 && outTwo == 0 && deemphOn == 1'b0, "R1", "outputs in reset", int'(outOne), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0 && deemphOn == 1'b0, "R1", "outputs after release", int'(outValid), 0);
    sendSample(1234, -5000, "R1");
    sendSample(32767, -32768, "R1");

    // R2 R3: left gain 127
    shiftWord(16'h007F, 1'b1);
    sendSample(1000, 777, "R3");
    sendSample(-1001, 777, "R3");
    // R4 R5: left muted, right untouched
    shiftWord(16'h0000, 1'b1);
    sendSample(-32768, 4321, "R4");
    // R2 R5: right gain 63
    shiftWord(16'h403F, 1'b1);
    sendSample(500, -20000, "R5");
    shiftWord(16'h00FF, 1'b1);
    sendSample(-32768, 32767, "R3");
    // R10: address 11 ignored
    shiftWord(16'hC000, 1'b1);
    sendSample(1111, 2222, "R10");
    // R11: shift without latch
    shiftWord(16'h0001, 1'b0);
    sendSample(1111, 2222, "R11");
    // Commit the word left in the shift register
    serLatch = 1'b1; repeat (4) @(negedge clk); serLatch = 1'b0; repeat (6) @(negedge clk);
    mAttL = 1;
    sendSample(25600, 100, "R2");
    shiftWord(16'h00FF, 1'b1);
    shiftWord(16'h40FF, 1'b1);

    // R6: swap, then mute both
    setMode(1, 0, 1'b0);
    sendSample(300, -400, "R6");
    setMode(3, 3, 1'b0);
    sendSample(300, -400, "R6");
    // R7: sum source, including extremes
    setMode(2, 2, 1'b0);
    sendSample(30000, 30001, "R7");
    sendSample(-32768, -32768, "R7");
    sendSample(-3, 0, "R7");
    // R8: de-emphasis flag
    setMode(0, 2, 1'b1);
    sendSample(10, 20, "R8");
    setMode(0, 1, 1'b0);
    sendSample(10, 20, "R8");

    // R9: outputs hold while no sample arrives
    sendSample(-7, 9, "R9");
    repeat (5) @(negedge clk);
    chk(outOne == -7 && outValid == 1'b0, "R9", "hold outOne", int'(outOne), -7);
    chk(outTwo == 9, "R9", "hold outTwo", int'(outTwo), 9);

    // R1: clear returns defaults
    shiftWord(16'h0010, 1'b1);
    setMode(3, 0, 1'b1);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(outOne == 0 && deemphOn == 1'b0, "R1", "clear outputs", int'(outOne), 0);
    rstN = 1'b1; modelReset();
    repeat (3) @(negedge clk);
    sendSample(-1234, 5678, "R1");

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R9", "pending expected items", q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule